// File: doc/BRIEF.md
# Brown-in Start-up Probe Sequencer

This block sequences a switching converter controller from the moment its supply rail reaches the start level up to the point where normal PWM may run. At that moment it turns off the start-up current source. It then emits a fixed burst of three low-energy probe gate pulses, during which the current-demand request is held at its floor. While the burst runs, the block watches the sampled output-overvoltage flag and the sampled line-above-turn-on flag.

The burst has three outcomes:

- **Overvoltage seen:** pulsing stops at once and the block latches a fault.
- **Line high enough:** after a clean burst, PWM is enabled.
- **Line too low:** the block parks in low-power mode for a fixed dwell. It then waits for the rail to sag to its reset level, re-enables the current source and probes again. This retry loop has no limit.

All timing is counted in clock cycles from parameters. The comparators, analog sensing and the PWM modulator are outside the block.

Top module: `brownin_probe_seq`

## Requirements
- R1: After reset `seq_state` is 0 (charging), `src_en` is 1, and `gate_req`, `cs_min`, `lowpwr_en`, `pwm_en` and `fault_lat` are 0.
- R2: While charging, the block waits with `src_en` high until `rail_start` is sampled high. It then spends exactly one cycle in state 1 (armed) with `src_en` low and `gate_req` low before the first probe pulse.
- R3: The probe burst (state 2) lasts 3*PRB_PERIOD cycles. In cycle k of the burst (k from 0), `gate_req` is 1 exactly when k mod PRB_PERIOD < PRB_WIDTH, which gives three pulses of PRB_WIDTH cycles each.
- R4: `cs_min` is 1 during every burst cycle and 0 in every other state; `pwm_en` and `src_en` stay 0 during the burst.
- R5: An `out_ovp` sampled high on a cycle where `gate_req` is 1 moves the block to state 6 (fault) on the next cycle, with `gate_req` 0 and `fault_lat` 1. An `out_ovp` on a burst cycle where `gate_req` is 0 has no effect.
- R6: In fault, `fault_lat` stays 1 and no pulse is issued, whatever `rail_start`, `line_ok` and `out_ovp` do, until `rail_reset` is sampled high. The block then returns to charging with `src_en` 1.
- R7: The line decision uses only the `line_ok` value sampled on the final cycle of the third pulse (burst cycle 2*PRB_PERIOD+PRB_WIDTH-1). If that value is 1, the cycle after the burst is state 5 (run) with `pwm_en` 1.
- R8: If the sampled line value is 0, the block enters state 3 (reset dwell) with `lowpwr_en` 1 for exactly RESET_CYC cycles, and `rail_reset` has no effect there. It then enters state 4 (drain) with `lowpwr_en` 1 until `rail_reset` is sampled high, after which it returns to charging with `src_en` 1 and `lowpwr_en` 0.
- R9: Failed attempts repeat without limit, and every retry produces the same three-pulse burst.
- R10: Once in run, the block stays there with `pwm_en` 1 and `gate_req` 0 whatever the comparator flags do, until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_start | input | 1 | Supply rail has reached its start threshold |
| rail_reset | input | 1 | Supply rail has fallen to its reset threshold |
| out_ovp | input | 1 | Sampled output voltage is above the overvoltage limit |
| line_ok | input | 1 | Sampled line level is above the turn-on threshold |
| gate_req | output | 1 | Probe gate pulse request |
| cs_min | output | 1 | Clamp peak-current demand to its minimum |
| src_en | output | 1 | Start-up current source enable |
| lowpwr_en | output | 1 | Low-power mode request |
| pwm_en | output | 1 | Normal PWM operation allowed |
| fault_lat | output | 1 | Latched overvoltage fault |
| seq_state | output | 3 | Sequencer state: 0 charge, 1 armed, 2 probe, 3 dwell, 4 drain, 5 run, 6 fault |

## Verification
The bench builds the block with PRB_PERIOD=5, PRB_WIDTH=2 and RESET_CYC=7. With these values a whole burst is 15 cycles and a dwell is 7 cycles. That makes it cheap to inject an overvoltage at every single burst cycle, and to confirm that only the injections landing on a high gate cycle latch a fault. The same small setting lets the bench sweep all four combinations of the decisive line sample against the line value on the other burst cycles. It also lets the bench run several back-to-back failed attempts through the dwell and drain loop and compare each burst, cycle by cycle, with the arithmetic pulse pattern.

// File: rtl/bps_pkg.sv
package bps_pkg;
   localparam int unsigned PROBE_PULSES = 3;

   typedef enum logic [2:0] {
      ST_CHARGE = 3'd0,
      ST_ARM    = 3'd1,
      ST_PROBE  = 3'd2,
      ST_DWELL  = 3'd3,
      ST_DRAIN  = 3'd4,
      ST_RUN    = 3'd5,
      ST_FAULT  = 3'd6
   } seq_state_e;
endpackage

// File: rtl/bps_pulse_gen.sv
module bps_pulse_gen #(
   parameter int unsigned PRB_PERIOD = 40,
   parameter int unsigned PRB_WIDTH  = 8,
   parameter int unsigned NUM_PULSES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic pulse_on,
   output logic sample_pt,
   output logic burst_done
);
   localparam int unsigned PH_W = $clog2(PRB_PERIOD);
   localparam int unsigned CN_W = $clog2(NUM_PULSES + 1);

   generate
      if (PRB_PERIOD < 2 || PRB_WIDTH < 1 || PRB_WIDTH >= PRB_PERIOD) begin : g_bad_timing
         $error("bps_pulse_gen: need 1 <= PRB_WIDTH < PRB_PERIOD");
      end
      if (NUM_PULSES < 1) begin : g_bad_count
         $error("bps_pulse_gen: NUM_PULSES must be at least 1");
      end
   endgenerate

   logic [PH_W-1:0] phase_q;
   logic [CN_W-1:0] cnt_q;
   logic            last_phase;
   logic            last_pulse;

   assign last_phase = (phase_q == PH_W'(PRB_PERIOD - 1));
   assign last_pulse = (cnt_q == CN_W'(NUM_PULSES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         cnt_q   <= '0;
      end else if (!run) begin
         phase_q <= '0;
         cnt_q   <= '0;
      end else if (last_phase) begin
         phase_q <= '0;
         cnt_q   <= cnt_q + CN_W'(1);
      end else begin
         phase_q <= phase_q + PH_W'(1);
      end
   end

   assign pulse_on   = run && (phase_q < PH_W'(PRB_WIDTH));
   assign sample_pt  = run && last_pulse && (phase_q == PH_W'(PRB_WIDTH - 1));
   assign burst_done = run && last_pulse && last_phase;
endmodule

// File: rtl/bps_dwell.sv
module bps_dwell #(
   parameter int unsigned DWELL_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   generate
      if (DWELL_CYC < 1) begin : g_bad
         $error("bps_dwell: DWELL_CYC must be at least 1");
      end else if (DWELL_CYC == 1) begin : g_single
         assign expired = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(DWELL_CYC);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (!run)    cnt_q <= '0;
            else              cnt_q <= cnt_q + CW'(1);
         end
         assign expired = run && (cnt_q == CW'(DWELL_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/brownin_probe_seq.sv
module brownin_probe_seq
   import bps_pkg::*;
#(
   parameter int unsigned PRB_PERIOD = 40,
   parameter int unsigned PRB_WIDTH  = 8,
   parameter int unsigned RESET_CYC  = 5000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rail_start,
   input  logic       rail_reset,
   input  logic       out_ovp,
   input  logic       line_ok,
   output logic       gate_req,
   output logic       cs_min,
   output logic       src_en,
   output logic       lowpwr_en,
   output logic       pwm_en,
   output logic       fault_lat,
   output logic [2:0] seq_state
);
   seq_state_e state_q, state_d;
   logic       line_q;
   logic       probing, pulse_on, sample_pt, burst_done;
   logic       dwelling, dwell_done;

   assign probing  = (state_q == ST_PROBE);
   assign dwelling = (state_q == ST_DWELL);

   bps_pulse_gen #(
      .PRB_PERIOD (PRB_PERIOD),
      .PRB_WIDTH  (PRB_WIDTH),
      .NUM_PULSES (PROBE_PULSES)
   ) u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (probing),
      .pulse_on   (pulse_on),
      .sample_pt  (sample_pt),
      .burst_done (burst_done)
   );

   bps_dwell #(
      .DWELL_CYC (RESET_CYC)
   ) u_dwell (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (dwelling),
      .expired (dwell_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_CHARGE: if (rail_start) state_d = ST_ARM;
         ST_ARM:    state_d = ST_PROBE;
         ST_PROBE: begin
            if (pulse_on && out_ovp) state_d = ST_FAULT;
            else if (burst_done)     state_d = line_q ? ST_RUN : ST_DWELL;
         end
         ST_DWELL:  if (dwell_done) state_d = ST_DRAIN;
         ST_DRAIN:  if (rail_reset) state_d = ST_CHARGE;
         ST_RUN:    state_d = ST_RUN;
         ST_FAULT:  if (rail_reset) state_d = ST_CHARGE;
         default:   state_d = ST_CHARGE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_CHARGE;
         line_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (sample_pt) line_q <= line_ok;
      end
   end

   assign gate_req  = pulse_on;
   assign cs_min    = probing;
   assign src_en    = (state_q == ST_CHARGE);
   assign lowpwr_en = dwelling || (state_q == ST_DRAIN);
   assign pwm_en    = (state_q == ST_RUN);
   assign fault_lat = (state_q == ST_FAULT);
   assign seq_state = state_q;
endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
   parameter int unsigned PRB_WIDTH = 8
) (
   input logic clk,
   input logic rst_n,
   input logic rail_reset,
   input logic out_ovp,
   input logic gate_req,
   input logic cs_min,
   input logic src_en,
   input logic lowpwr_en,
   input logic pwm_en,
   input logic fault_lat
);
   int unsigned hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_run <= 0;
      else if (gate_req) hi_run <= hi_run + 1;
      else               hi_run <= 0;
   end

   AST_ARM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(src_en) |-> !gate_req); // R2
   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      gate_req |-> (hi_run < PRB_WIDTH)); // R3
   AST_PROBE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      gate_req |-> (cs_min && !src_en && !pwm_en)); // R4
   AST_OVP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_req && out_ovp) |=> (fault_lat && !gate_req)); // R5
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_lat && !rail_reset) |=> fault_lat); // R6
   AST_LOWPWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr_en |-> (!gate_req && !pwm_en && !src_en)); // R8
   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_en |=> pwm_en); // R10
endmodule

bind brownin_probe_seq bps_chk #(
   .PRB_WIDTH (PRB_WIDTH)
) u_bps_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rail_reset (rail_reset),
   .out_ovp    (out_ovp),
   .gate_req   (gate_req),
   .cs_min     (cs_min),
   .src_en     (src_en),
   .lowpwr_en  (lowpwr_en),
   .pwm_en     (pwm_en),
   .fault_lat  (fault_lat)
);

// File: tb/test_brownin_probe_seq.sv
`timescale 1ns/1ps
module test_brownin_probe_seq;
   localparam int P  = 5;
   localparam int W  = 2;
   localparam int RC = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rail_start = 1'b0, rail_reset = 1'b0, out_ovp = 1'b0, line_ok = 1'b0;
   logic       gate_req, cs_min, src_en, lowpwr_en, pwm_en, fault_lat;
   logic [2:0] seq_state;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   brownin_probe_seq #(
      .PRB_PERIOD (P),
      .PRB_WIDTH  (W),
      .RESET_CYC  (RC)
   ) i_brownin_probe_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rail_start (rail_start),
      .rail_reset (rail_reset),
      .out_ovp    (out_ovp),
      .line_ok    (line_ok),
      .gate_req   (gate_req),
      .cs_min     (cs_min),
      .src_en     (src_en),
      .lowpwr_en  (lowpwr_en),
      .pwm_en     (pwm_en),
      .fault_lat  (fault_lat),
      .seq_state  (seq_state)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rail_start = 0; rail_reset = 0; out_ovp = 0; line_ok = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 state", seq_state, 0);
      chk("R1 src_en", src_en, 1);
      chk("R1 quiet outputs", {gate_req, cs_min, lowpwr_en, pwm_en, fault_lat}, 0);
   endtask

   // Starts at a negedge in charging state; ends at the negedge after the outcome.
   task automatic attempt(input int ovp_k, input bit ll, input bit lo);
      bit hit = 0;
      rail_start = 1;
      @(negedge clk);
      chk("R2 armed state", seq_state, 1);
      chk("R2 src off while armed", src_en, 0);
      chk("R2 no gate while armed", gate_req, 0);
      rail_start = 0;
      @(negedge clk);
      for (int k = 0; k < 3 * P; k++) begin
         bit eg = ((k % P) < W);
         chk("R3 burst state", seq_state, 2);
         chk("R3 gate pattern", gate_req, int'(eg));
         chk("R4 floor demand", cs_min, 1);
         chk("R4 no pwm/src in burst", {pwm_en, src_en}, 0);
         out_ovp = (k == ovp_k);
         line_ok = (k == 2 * P + W - 1) ? ll : lo;
         @(negedge clk);
         if (k == ovp_k && eg) begin
            chk("R5 fault state", seq_state, 6);
            chk("R5 gate stopped", gate_req, 0);
            chk("R5 fault flag", fault_lat, 1);
            hit = 1;
            break;
         end
      end
      out_ovp = 0; line_ok = 0;
      if (!hit) begin
         chk("R7 decision state", seq_state, ll ? 5 : 3);
         chk("R7 pwm_en", pwm_en, int'(ll));
         chk("R4 floor released", cs_min, 0);
         chk("R5 ignored ovp no fault", fault_lat, 0);
      end
   endtask

   task automatic dwell_drain();
      for (int i = 0; i < RC; i++) begin
         chk("R8 dwell state", seq_state, 3);
         chk("R8 lowpwr in dwell", lowpwr_en, 1);
         rail_reset = (i < RC - 1);
         @(negedge clk);
      end
      for (int j = 0; j < 3; j++) begin
         chk("R8 drain state", seq_state, 4);
         chk("R8 lowpwr in drain", lowpwr_en, 1);
         rail_reset = (j == 2);
         @(negedge clk);
      end
      rail_reset = 0;
      chk("R8 back to charge", seq_state, 0);
      chk("R8 src re-enabled", src_en, 1);
      chk("R8 lowpwr released", lowpwr_en, 0);
   endtask

   task automatic fault_hold();
      for (int j = 0; j < 4; j++) begin
         chk("R6 fault held", seq_state, 6);
         chk("R6 fault flag", fault_lat, 1);
         chk("R6 no pulses", gate_req, 0);
         rail_start = 1; line_ok = 1; out_ovp = j[0];
         rail_reset = (j == 3);
         @(negedge clk);
      end
      rail_start = 0; line_ok = 0; out_ovp = 0; rail_reset = 0;
      chk("R6 exit to charge", seq_state, 0);
      chk("R6 src on", src_en, 1);
      chk("R6 fault cleared", fault_lat, 0);
   endtask

   task automatic run_hold();
      for (int j = 0; j < 5; j++) begin
         chk("R10 run held", seq_state, 5);
         chk("R10 pwm_en", pwm_en, 1);
         chk("R10 no probe gate", gate_req, 0);
         rail_start = j[0]; rail_reset = j[1]; out_ovp = 1; line_ok = 0;
         @(negedge clk);
      end
      rail_start = 0; rail_reset = 0; out_ovp = 0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R2: no start while flag is low
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         chk("R2 waits in charge", seq_state, 0);
         chk("R2 src held", src_en, 1);
      end
      // R5: overvoltage injected at every burst cycle (and none)
      for (int k = -1; k < 3 * P; k++) begin
         do_reset();
         attempt(k, 1'b1, 1'b0);
         if (k >= 0 && (k % P) < W) fault_hold();
         else run_hold();
      end
      // R7: decisive sample versus the rest of the burst
      for (int ll = 0; ll < 2; ll++) begin
         for (int lo = 0; lo < 2; lo++) begin
            do_reset();
            attempt(-1, ll[0], lo[0]);
            if (ll != 0) run_hold();
            else dwell_drain();
         end
      end
      // R9: repeated failing attempts, then success
      do_reset();
      for (int a = 0; a < 3; a++) begin
         attempt(-1, 1'b0, 1'b1);
         dwell_drain();
      end
      attempt(-1, 1'b1, 1'b0);
      chk("R9 success after retries", pwm_en, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule